// File: doc/BRIEF.md
# Sorted Release-Time Timer Queue

This block holds deferred task requests until their moment arrives. Each request carries a release time and a task identifier. The block keeps the requests in a list ordered by release time, inside a fixed pool of storage slots. A free-running time base is compared against the earliest entry. When that entry falls due, the block sends its identifier out as a one-cycle pulse and removes it. It keeps doing this, one entry per cycle, until the list is empty or the next entry is still in the future.

All time comparisons use the signed difference of two values of the time width. Ordering and expiry therefore stay correct when the time base wraps, as long as the pending times lie within half the time range of each other. The block has two resting modes. In Idle the list is empty and the timer enable is low. In Wait the list holds at least one entry and the enable is high. Insertion walks the list one link per cycle, and the enqueue port is not ready while a walk or a drain is in progress.

Top module: `release_timer_queue`

## Requirements
- R1: After reset, q_empty is 1, tmr_en is 0, enq_ready is 1, q_full is 0, rel_valid is 0 and ovf_err is 0.
- R2: An entry is due when (time_now − release time), taken as a signed TIME_W-bit value, is zero or more. A due entry is sent out as a one-cycle rel_valid pulse with its identifier on rel_id. No entry is ever released before it is due.
- R3: Entries are released in order of release time, with comparisons made by signed difference. This order holds across a wrap of the time base.
- R4: Entries with equal release times are released in the order they were accepted.
- R5: If an accepted entry becomes the new head and is already due, its rel_valid pulse appears exactly one clock after the edge that accepted it.
- R6: When several entries are due, they are released on consecutive cycles, one per cycle, until the list is empty or the head is not yet due.
- R7: tmr_en is 0 only in Idle, and Idle implies q_empty is 1. Accepting an entry into an empty list raises tmr_en. Releasing the last entry returns tmr_en to 0 once the drain ends.
- R8: An enqueue is taken only on a clock edge where enq_valid and enq_ready are both 1. Right after a non-full enqueue is accepted, enq_ready drops for the insertion walk or the drain, and it returns to 1 afterwards.
- R9: The list holds up to DEPTH entries, and q_full is 1 when all DEPTH slots are in use. An enqueue presented while q_full is 1 is dropped and sets ovf_err. ovf_err stays 1 until reset, and the stored entries are not changed.
- R10: An insertion behind k existing entries keeps enq_ready low for at most DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue request |
| enq_time | input | TIME_W | Release time of the new entry |
| enq_id | input | ID_W | Task identifier of the new entry |
| enq_ready | output | 1 | Block can take an enqueue this cycle |
| q_full | output | 1 | All slots are occupied |
| time_now | input | TIME_W | Free-running time base |
| rel_valid | output | 1 | One-cycle release pulse |
| rel_id | output | ID_W | Identifier of the released entry |
| q_empty | output | 1 | List holds no entry |
| tmr_en | output | 1 | Timer enable, high in Wait and while busy |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
Random release times are scattered around a time base that crosses the wrap point. Some are already due and some lie in the future. This tells a correct signed comparison apart from an unsigned one, and a correct sorted insertion apart from a misplaced link. Directed patterns cover the rest. A batch of equal release times separates stable insertion from insertion ahead of equals. A burst that all falls due on one time step shows that the drain releases back-to-back rather than one per time-base change. An already-due entry into an empty list checks the one-cycle forced check. Filling every slot and then pushing once more, with an insertion at the tail, exposes faults in the overflow handling, in the free-list handling and in the bound on the walk.

// File: rtl/tq_pkg.sv
`timescale 1ns/1ps
package tq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_WALK  = 2'd2,
      ST_DRAIN = 2'd3
   } tq_state_e;
endpackage

// File: rtl/tq_cmp.sv
`timescale 1ns/1ps
module tq_cmp #(
   parameter int TIME_W = 32
) (
   input  logic [TIME_W-1:0] now_t,
   input  logic [TIME_W-1:0] head_t,
   input  logic [TIME_W-1:0] cand_t,
   input  logic [TIME_W-1:0] held_t,
   input  logic [TIME_W-1:0] walk_t,
   output logic              head_due,
   output logic              cand_first,
   output logic              walk_pass
);
   logic [TIME_W-1:0] d_due, d_first, d_walk;

   // wrap-safe differences: the sign bit decides the order
   assign d_due   = now_t  - head_t;
   assign d_first = head_t - cand_t;
   assign d_walk  = held_t - walk_t;

   assign head_due   = ~d_due[TIME_W-1];
   assign cand_first = ~d_first[TIME_W-1] & (|d_first);
   assign walk_pass  = ~d_walk[TIME_W-1];
endmodule

// File: rtl/tq_pool.sv
`timescale 1ns/1ps
module tq_pool #(
   parameter int DEPTH  = 8,
   parameter int TIME_W = 32,
   parameter int ID_W   = 8,
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [TIME_W-1:0] new_t_i,
   input  logic [ID_W-1:0]   new_id_i,
   input  logic              link_head_i,
   input  logic              link_after_i,
   input  logic [IW-1:0]     after_idx_i,
   input  logic [IW-1:0]     new_idx_i,
   input  logic              pop_i,
   input  logic [IW-1:0]     walk_idx_i,
   output logic [IW-1:0]     free_idx_o,
   output logic [IW-1:0]     head_idx_o,
   output logic [TIME_W-1:0] head_t_o,
   output logic [ID_W-1:0]   head_id_o,
   output logic [IW-1:0]     walk_next_o,
   output logic [TIME_W-1:0] walk_next_t_o,
   output logic [CW-1:0]     cnt_o
);
   logic [TIME_W-1:0] t_mem  [DEPTH];
   logic [ID_W-1:0]   id_mem [DEPTH];
   logic [IW-1:0]     nxt    [DEPTH];
   logic [IW-1:0]     head_q, free_q;
   logic [CW-1:0]     cnt_q;

   // slot payload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < DEPTH; s++) begin
            t_mem[s]  <= '0;
            id_mem[s] <= '0;
         end
      end else if (alloc_i) begin
         t_mem[free_q]  <= new_t_i;
         id_mem[free_q] <= new_id_i;
      end
   end

   // links: both the sorted list and the free list live here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < DEPTH; s++)
            nxt[s] <= IW'((s + 1) % DEPTH);
      end else begin
         for (int s = 0; s < DEPTH; s++) begin
            if (link_head_i && new_idx_i == IW'(s))
               nxt[s] <= head_q;
            else if (link_after_i && new_idx_i == IW'(s))
               nxt[s] <= nxt[after_idx_i];
            else if (link_after_i && after_idx_i == IW'(s))
               nxt[s] <= new_idx_i;
            else if (pop_i && head_q == IW'(s))
               nxt[s] <= free_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         free_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (alloc_i)
            free_q <= nxt[free_q];
         else if (pop_i)
            free_q <= head_q;

         if (link_head_i)
            head_q <= new_idx_i;
         else if (pop_i)
            head_q <= nxt[head_q];

         if (alloc_i && !pop_i)
            cnt_q <= cnt_q + CW'(1);
         else if (pop_i && !alloc_i)
            cnt_q <= cnt_q - CW'(1);
      end
   end

   assign free_idx_o    = free_q;
   assign head_idx_o    = head_q;
   assign head_t_o      = t_mem[head_q];
   assign head_id_o     = id_mem[head_q];
   assign walk_next_o   = nxt[walk_idx_i];
   assign walk_next_t_o = t_mem[nxt[walk_idx_i]];
   assign cnt_o         = cnt_q;
endmodule

// File: rtl/tq_ctrl.sv
`timescale 1ns/1ps
module tq_ctrl
   import tq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TIME_W = 32,
   parameter int ID_W   = 8,
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid_i,
   input  logic [TIME_W-1:0] enq_t_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic              head_due_i,
   input  logic              cand_first_i,
   input  logic              walk_pass_i,
   input  logic [ID_W-1:0]   head_id_i,
   input  logic [IW-1:0]     free_idx_i,
   input  logic [IW-1:0]     head_idx_i,
   input  logic [IW-1:0]     walk_next_i,
   output logic              alloc_o,
   output logic              link_head_o,
   output logic              link_after_o,
   output logic              pop_o,
   output logic [IW-1:0]     cur_idx_o,
   output logic [IW-1:0]     new_idx_o,
   output logic [TIME_W-1:0] held_t_o,
   output logic              enq_ready_o,
   output logic              rel_valid_o,
   output logic [ID_W-1:0]   rel_id_o,
   output logic              tmr_en_o,
   output logic              ovf_o
);
   tq_state_e         st_q, st_d;
   logic [IW-1:0]     cur_q, cur_d, nidx_q, nidx_d;
   logic [CW-1:0]     rem_q, rem_d;
   logic [TIME_W-1:0] nt_q, nt_d;
   logic              ovf_set, rel_set;
   logic              empty, full;

   assign empty = (cnt_i == '0);
   assign full  = (cnt_i == CW'(DEPTH));

   always_comb begin
      st_d         = st_q;
      cur_d        = cur_q;
      rem_d        = rem_q;
      nt_d         = nt_q;
      nidx_d       = nidx_q;
      alloc_o      = 1'b0;
      link_head_o  = 1'b0;
      link_after_o = 1'b0;
      pop_o        = 1'b0;
      ovf_set      = 1'b0;
      rel_set      = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_WAIT: begin
            if (enq_valid_i) begin
               if (full) begin
                  ovf_set = 1'b1;
               end else if (empty || cand_first_i) begin
                  alloc_o     = 1'b1;
                  link_head_o = 1'b1;
                  st_d        = ST_DRAIN;
               end else begin
                  alloc_o = 1'b1;
                  nt_d    = enq_t_i;
                  nidx_d  = free_idx_i;
                  cur_d   = head_idx_i;
                  rem_d   = cnt_i - CW'(1);
                  st_d    = ST_WALK;
               end
            end else if (!empty && head_due_i) begin
               st_d = ST_DRAIN;
            end
         end
         ST_WALK: begin
            if (rem_q != '0 && walk_pass_i) begin
               cur_d = walk_next_i;
               rem_d = rem_q - CW'(1);
            end else begin
               link_after_o = 1'b1;
               st_d         = ST_WAIT;
            end
         end
         ST_DRAIN: begin
            if (!empty && head_due_i) begin
               pop_o   = 1'b1;
               rel_set = 1'b1;
            end else begin
               st_d = empty ? ST_IDLE : ST_WAIT;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cur_q       <= '0;
         rem_q       <= '0;
         nt_q        <= '0;
         nidx_q      <= '0;
         rel_valid_o <= 1'b0;
         rel_id_o    <= '0;
         ovf_o       <= 1'b0;
      end else begin
         st_q        <= st_d;
         cur_q       <= cur_d;
         rem_q       <= rem_d;
         nt_q        <= nt_d;
         nidx_q      <= nidx_d;
         rel_valid_o <= rel_set;
         if (rel_set)
            rel_id_o <= head_id_i;
         if (ovf_set)
            ovf_o <= 1'b1;
      end
   end

   assign cur_idx_o   = cur_q;
   assign new_idx_o   = (st_q == ST_WALK) ? nidx_q : free_idx_i;
   assign held_t_o    = nt_q;
   assign enq_ready_o = (st_q == ST_IDLE) || (st_q == ST_WAIT);
   assign tmr_en_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/release_timer_queue.sv
`timescale 1ns/1ps
module release_timer_queue #(
   parameter int DEPTH  = 8,
   parameter int TIME_W = 32,
   parameter int ID_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [TIME_W-1:0] enq_time,
   input  logic [ID_W-1:0]   enq_id,
   output logic              enq_ready,
   output logic              q_full,
   input  logic [TIME_W-1:0] time_now,
   output logic              rel_valid,
   output logic [ID_W-1:0]   rel_id,
   output logic              q_empty,
   output logic              tmr_en,
   output logic              ovf_err
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "release_timer_queue: DEPTH must be at least 2");
      end
      if (TIME_W < 2) begin : g_bad_time
         initial $fatal(1, "release_timer_queue: TIME_W must be at least 2");
      end
      if (ID_W < 1) begin : g_bad_id
         initial $fatal(1, "release_timer_queue: ID_W must be at least 1");
      end
   endgenerate

   logic              alloc, link_head, link_after, pop;
   logic [IW-1:0]     cur_idx, new_idx, free_idx, head_idx, walk_next;
   logic [TIME_W-1:0] head_t, walk_next_t, held_t;
   logic [ID_W-1:0]   head_id;
   logic [CW-1:0]     occ;
   logic              head_due, cand_first, walk_pass;

   tq_pool #(.DEPTH(DEPTH), .TIME_W(TIME_W), .ID_W(ID_W)) u_pool (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc),
      .new_t_i      (enq_time),
      .new_id_i     (enq_id),
      .link_head_i  (link_head),
      .link_after_i (link_after),
      .after_idx_i  (cur_idx),
      .new_idx_i    (new_idx),
      .pop_i        (pop),
      .walk_idx_i   (cur_idx),
      .free_idx_o   (free_idx),
      .head_idx_o   (head_idx),
      .head_t_o     (head_t),
      .head_id_o    (head_id),
      .walk_next_o  (walk_next),
      .walk_next_t_o(walk_next_t),
      .cnt_o        (occ)
   );

   tq_cmp #(.TIME_W(TIME_W)) u_cmp (
      .now_t     (time_now),
      .head_t    (head_t),
      .cand_t    (enq_time),
      .held_t    (held_t),
      .walk_t    (walk_next_t),
      .head_due  (head_due),
      .cand_first(cand_first),
      .walk_pass (walk_pass)
   );

   tq_ctrl #(.DEPTH(DEPTH), .TIME_W(TIME_W), .ID_W(ID_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enq_valid_i (enq_valid),
      .enq_t_i     (enq_time),
      .cnt_i       (occ),
      .head_due_i  (head_due),
      .cand_first_i(cand_first),
      .walk_pass_i (walk_pass),
      .head_id_i   (head_id),
      .free_idx_i  (free_idx),
      .head_idx_i  (head_idx),
      .walk_next_i (walk_next),
      .alloc_o     (alloc),
      .link_head_o (link_head),
      .link_after_o(link_after),
      .pop_o       (pop),
      .cur_idx_o   (cur_idx),
      .new_idx_o   (new_idx),
      .held_t_o    (held_t),
      .enq_ready_o (enq_ready),
      .rel_valid_o (rel_valid),
      .rel_id_o    (rel_id),
      .tmr_en_o    (tmr_en),
      .ovf_o       (ovf_err)
   );

   assign q_empty = (occ == '0);
   assign q_full  = (occ == CW'(DEPTH));
endmodule

// File: rtl/release_timer_queue_chk.sv
`timescale 1ns/1ps
module release_timer_queue_chk #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enq_valid,
   input logic          enq_ready,
   input logic          q_full,
   input logic          q_empty,
   input logic          rel_valid,
   input logic          tmr_en,
   input logic          ovf_err,
   input logic [CW-1:0] occ
);
   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   assert_ovf_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && q_full) |=> ovf_err);

   assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |-> q_empty);

   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && !q_full) |=> !enq_ready);

   assert_release_has_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> $past(!q_empty));
endmodule

bind release_timer_queue release_timer_queue_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enq_valid(enq_valid),
   .enq_ready(enq_ready),
   .q_full   (q_full),
   .q_empty  (q_empty),
   .rel_valid(rel_valid),
   .tmr_en   (tmr_en),
   .ovf_err  (ovf_err),
   .occ      (occ)
);

// File: tb/release_timer_queue_tb.sv
`timescale 1ns/1ps
module release_timer_queue_tb;
   localparam int DEPTH = 8;
   localparam int TW    = 32;
   localparam int IDW   = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           enq_valid = 1'b0;
   logic [TW-1:0]  enq_time = '0;
   logic [IDW-1:0] enq_id = '0;
   logic           enq_ready, q_full, rel_valid, q_empty, tmr_en, ovf_err;
   logic [IDW-1:0] rel_id;
   logic [TW-1:0]  tnow = '0;
   logic [TW-1:0]  now_edge = '0;

   always #2.5 clk = ~clk;

   release_timer_queue #(.DEPTH(DEPTH), .TIME_W(TW), .ID_W(IDW)) u_dut (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_time(enq_time),
      .enq_id(enq_id), .enq_ready(enq_ready), .q_full(q_full), .time_now(tnow),
      .rel_valid(rel_valid), .rel_id(rel_id), .q_empty(q_empty),
      .tmr_en(tmr_en), .ovf_err(ovf_err)
   );

   int nchk = 0, nerr = 0, cyc = 0;
   bit done = 0;

   // reference list, stable sorted by release time
   logic [TW-1:0]  mt  [16];
   logic [IDW-1:0] mid [16];
   int             mcnt = 0;
   int             rel_seen = 0;
   int             rel_cyc [64];
   logic [IDW-1:0] rel_ids [64];
   logic [IDW-1:0] next_id = 8'd1;

   function automatic bit is_due(input logic [TW-1:0] n, input logic [TW-1:0] t);
      logic [TW-1:0] d;
      d = n - t;
      return !d[TW-1];
   endfunction

   function automatic bit later(input logic [TW-1:0] a, input logic [TW-1:0] b);
      logic [TW-1:0] d;
      d = a - b;
      return !d[TW-1] && (d != 0);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_push(input logic [TW-1:0] t, input logic [IDW-1:0] id);
      int pos;
      pos = mcnt;
      for (int i = 0; i < mcnt; i++)
         if (later(mt[i], t)) begin pos = i; break; end
      for (int i = mcnt; i > pos; i--) begin
         mt[i] = mt[i-1]; mid[i] = mid[i-1];
      end
      mt[pos] = t; mid[pos] = id;
      mcnt++;
   endtask

   always @(posedge clk) begin
      cyc      <= cyc + 1;
      now_edge <= tnow;
   end

   // release monitor: compares every pulse with the reference head
   always @(negedge clk) begin
      if (rst_n && rel_valid) begin
         if (mcnt == 0) begin
            chk(0, "R3 release with empty reference", rel_id, 0);
         end else begin
            chk(rel_id == mid[0], "R3 release order", rel_id, mid[0]);
            chk(is_due(now_edge, mt[0]), "R2 released before due", now_edge, mt[0]);
            for (int i = 0; i < mcnt - 1; i++) begin
               mt[i] = mt[i+1]; mid[i] = mid[i+1];
            end
            mcnt--;
         end
         if (rel_seen < 64) begin
            rel_cyc[rel_seen] = cyc;
            rel_ids[rel_seen] = rel_id;
         end
         rel_seen++;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic enq(input logic [TW-1:0] t, output bit acc, output int acc_cyc);
      bit was_full;
      while (!enq_ready) step();
      enq_valid = 1'b1;
      enq_time  = t;
      enq_id    = next_id;
      was_full  = q_full;
      step();
      acc_cyc   = cyc;
      enq_valid = 1'b0;
      acc       = !was_full;
      if (acc) model_push(t, next_id);
      next_id   = next_id + 8'd1;
   endtask

   task automatic settle(input string tag);
      repeat (2 * DEPTH + 6) step();
      chk(q_empty == (mcnt == 0), {tag, " R7 empty flag"}, q_empty, mcnt == 0);
      chk(tmr_en == !q_empty, {tag, " R7 timer enable"}, tmr_en, !q_empty);
      if (mcnt != 0)
         chk(!is_due(tnow, mt[0]), {tag, " R6 due entry left behind"}, mt[0], tnow);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      bit acc;
      int ac, base, n;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      chk(q_empty == 1 && tmr_en == 0, "R1 empty and timer off", {q_empty, tmr_en}, 2'b10);
      chk(enq_ready == 1 && q_full == 0, "R1 ready, not full", {enq_ready, q_full}, 2'b10);
      chk(rel_valid == 0 && ovf_err == 0, "R1 no release, no error", {rel_valid, ovf_err}, 0);

      // R5 already-due entry becomes head: pulse one cycle after acceptance
      tnow = 32'd1000;
      base = rel_seen;
      enq(32'd990, acc, ac);
      repeat (3) step();
      chk(rel_seen == base + 1, "R5 forced check released", rel_seen - base, 1);
      chk(rel_cyc[base] - ac == 1, "R5 release latency", rel_cyc[base] - ac, 1);
      chk(tmr_en == 0 && q_empty == 1, "R7 back to idle", {tmr_en, q_empty}, 2'b01);

      // R2 exact due boundary, R7 wait mode
      base = rel_seen;
      enq(32'd1005, acc, ac);
      repeat (3) step();
      chk(tmr_en == 1 && q_empty == 0, "R7 wait mode", {tmr_en, q_empty}, 2'b10);
      tnow = 32'd1004;
      repeat (4) step();
      chk(rel_seen == base, "R2 no release one tick early", rel_seen - base, 0);
      tnow = 32'd1005;
      repeat (4) step();
      chk(rel_seen == base + 1, "R2 release at due time", rel_seen - base, 1);

      // R4 equal times keep arrival order, R6 back-to-back drain
      base = rel_seen;
      enq(32'd2000, acc, ac);
      enq(32'd2000, acc, ac);
      enq(32'd1990, acc, ac);
      enq(32'd2000, acc, ac);
      settle("eq");
      tnow = 32'd2000;
      settle("eq");
      chk(rel_seen == base + 4, "R6 all due released", rel_seen - base, 4);
      chk(rel_ids[base] == next_id - 8'd2, "R4 earlier time first", rel_ids[base], next_id - 8'd2);
      chk(rel_ids[base+1] == next_id - 8'd4, "R4 arrival order 1", rel_ids[base+1], next_id - 8'd4);
      chk(rel_ids[base+2] == next_id - 8'd3, "R4 arrival order 2", rel_ids[base+2], next_id - 8'd3);
      chk(rel_ids[base+3] == next_id - 8'd1, "R4 arrival order 3", rel_ids[base+3], next_id - 8'd1);
      for (int k = 1; k < 4; k++)
         chk(rel_cyc[base+k] - rel_cyc[base+k-1] == 1, "R6 consecutive releases",
             rel_cyc[base+k] - rel_cyc[base+k-1], 1);

      // R3 ordering across the wrap of the time base
      tnow = 32'hFFFF_FFF0;
      base = rel_seen;
      enq(32'h0000_0004, acc, ac);
      enq(32'hFFFF_FFF8, acc, ac);
      enq(32'hFFFF_FFFC, acc, ac);
      repeat (8) begin
         tnow = tnow + 32'd4;
         step();
      end
      settle("wrap");
      chk(rel_seen == base + 3, "R3 wrap count", rel_seen - base, 3);
      chk(rel_ids[base] == next_id - 8'd2, "R3 wrap first", rel_ids[base], next_id - 8'd2);
      chk(rel_ids[base+2] == next_id - 8'd3, "R3 wrap last", rel_ids[base+2], next_id - 8'd3);

      // random phase around a second wrap
      tnow = 32'hFFFF_FA00;
      for (int it = 0; it < 400; it++) begin
         if (($urandom % 4) < 2 && mcnt < DEPTH) begin
            enq(tnow + ($urandom % 220) - 32'd20, acc, ac);
            chk(acc, "R8 enqueue taken below capacity", acc, 1);
         end else begin
            tnow = tnow + ($urandom % 25);
            step();
         end
         if (it % 50 == 49) settle("rand");
      end
      tnow = tnow + 32'd400;
      settle("rand end");
      chk(mcnt == 0 && q_empty, "R6 random drain complete", mcnt, 0);

      // R9, R10 fill with increasing times, tail insertion bound
      base = rel_seen;
      for (int k = 0; k < DEPTH; k++) begin
         enq(tnow + 32'd100 + 32'(k * 10), acc, ac);
         if (k == DEPTH - 1) begin
            n = 0;
            while (!enq_ready) begin step(); n++; end
            chk(n >= 1 && n <= DEPTH, "R10 tail walk bound", n, DEPTH);
         end
      end
      chk(q_full == 1 && ovf_err == 0, "R9 full without error", {q_full, ovf_err}, 2'b10);
      enq(tnow + 32'd50, acc, ac);
      step();
      chk(ovf_err == 1 && !acc, "R9 overflow flagged", ovf_err, 1);
      chk(q_full == 1, "R9 content kept", q_full, 1);
      repeat (5) step();
      chk(ovf_err == 1, "R9 overflow sticky", ovf_err, 1);
      tnow = tnow + 32'd300;
      settle("ovf");
      chk(rel_seen == base + DEPTH, "R9 only stored entries released", rel_seen - base, DEPTH);
      chk(ovf_err == 1, "R9 sticky after drain", ovf_err, 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule